// File: doc/BRIEF.md
# Period-Gated Reciprocal Frequency Meter

The block measures the frequency of a slow, steady input signal against a fast reference clock. Software first writes the expected number of input cycles for one gate: the nominal input frequency times the gate time in seconds. It then pulses a start strobe. The block waits for a rising input edge, which opens the gate. From there it counts the reference cycles that pass until that many further input periods have finished. It then freezes the elapsed count and raises a done flag. Software works out the frequency as `preset x f_ref / ref_total`.

The input is sampled through a synchronizer into the reference-clock domain. A loadable down counter tracks the input periods that remain. The elapsed time lives in a two-stage counter: a narrow fast stage whose wrap advances a wide slow stage. If the slow stage wraps before the gate closes, a sticky flag marks the result as unusable. The intended input range is roughly 31 kHz to 39 kHz, measured only while the input is steady.

Top module: `recip_freq_meter`

## Requirements
- R1: While reset is asserted and after its release, `done`, `overflow`, `ref_total` and `preset_out` are all zero until the first start.
- R2: On the first clock after a cycle with `start` high, `preset_out` equals the `preset_in` value sampled with the strobe, and `done`, `overflow` and `ref_total` are zero.
- R3: With `preset_in` = N > 0, `ref_total` ends equal to the number of reference cycles between the first input rise after start (the arming rise) and the N-th input rise after it.
- R4: `done` rises on the fourth rising `clk_ref` edge after the input rise that closes the gate, and it stays high until the next start.
- R5: While `done` is high, further input rises change neither `ref_total` nor `done`.
- R6: The elapsed count is `{high stage, low stage}` in binary, with `ref_total[LO_W-1:0]` as the fast stage. A wrap of the fast stage adds one to the slow stage, so totals above 2^LO_W read correctly.
- R7: If the slow stage wraps while counting, `overflow` goes high and stays high until the next start. `ref_total` then holds the elapsed count modulo 2^(LO_W+HI_W).
- R8: With `preset_in` = 0, the arming rise completes the measurement with `ref_total` = 0, and `done` is timed from that rise as in R4.
- R9: A start during a measurement abandons it. The new preset is loaded and the block waits for a fresh arming rise.
- R10: With no input rises after start, `done` stays low and `ref_total` stays zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Fast reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle strobe: load preset, clear results, arm |
| preset_in | input | PRESET_W | Number of input periods in the gate |
| sig_in | input | 1 | Asynchronous input signal being measured |
| done | output | 1 | Result valid; held until next start |
| overflow | output | 1 | Slow count stage wrapped during the gate |
| preset_out | output | PRESET_W | Preset used for the current result |
| ref_total | output | LO_W+HI_W | Elapsed reference cycles over the gate |

## Verification
`preset_out` and the cleared results are due one reference cycle after the start strobe. `done`, `ref_total` and `overflow` are due on the fourth reference edge after the closing input rise: two synchronizer flops, one decrement cycle and one state update. The driver drives the input on falling clock edges in whole reference periods and time-stamps the closing rise. It pushes the expected total, preset and overflow into a queue. The monitor samples on falling edges, pops an entry when `done` first appears, and checks that the latency is exactly four cycles.

// File: rtl/recip_pkg.sv
package recip_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_COUNT = 2'd2,
    ST_DONE  = 2'd3
  } meter_state_t;
endpackage

// File: rtl/recip_rst_sync.sv
// Asynchronous assert, synchronous release of the active-low reset.
module recip_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/recip_edge_sync.sv
// Brings the asynchronous input into the clock domain and flags rising edges.
module recip_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [STAGES:0] pipe_q;
  logic [STAGES:0] pipe_d;

  always_comb pipe_d = {pipe_q[STAGES-1:0], async_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= pipe_d;
  end

  assign rise = pipe_q[STAGES-1] & ~pipe_q[STAGES];
endmodule

// File: rtl/recip_down_ctr.sv
// Loadable counter of remaining input periods.
module recip_down_ctr #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         zero
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)     cnt_d = load_val;
    else if (dec) cnt_d = cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/recip_ref_ctr.sv
// Two-stage elapsed-time counter: narrow fast stage carrying into wide slow stage.
module recip_ref_ctr #(
  parameter int LO_W = 8,
  parameter int HI_W = 32,
  localparam int TOT_W = LO_W + HI_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  output logic [TOT_W-1:0] total,
  output logic             wrap
);
  logic [LO_W-1:0] lo_q, lo_d;
  logic [HI_W-1:0] hi_q, hi_d;
  logic            lo_carry;
  logic            hi_en;

  assign lo_carry = &lo_q;
  assign hi_en    = en & lo_carry;

  always_comb begin
    lo_d = lo_q;
    if (clr)     lo_d = '0;
    else if (en) lo_d = lo_q + LO_W'(1);
  end

  always_comb begin
    hi_d = hi_q;
    if (clr)        hi_d = '0;
    else if (hi_en) hi_d = hi_q + HI_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lo_q <= '0;
    else        lo_q <= lo_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_q <= '0;
    else        hi_q <= hi_d;
  end

  assign total = {hi_q, lo_q};
  assign wrap  = hi_en & (&hi_q) & ~clr;
endmodule

// File: rtl/recip_freq_meter.sv
module recip_freq_meter #(
  parameter int PRESET_W = 24,
  parameter int LO_W     = 8,
  parameter int HI_W     = 32,
  parameter int SYNC_W   = 2,
  localparam int TOT_W   = LO_W + HI_W
) (
  input  logic                clk_ref,
  input  logic                rst_n,
  input  logic                start,
  input  logic [PRESET_W-1:0] preset_in,
  input  logic                sig_in,
  output logic                done,
  output logic                overflow,
  output logic [PRESET_W-1:0] preset_out,
  output logic [TOT_W-1:0]    ref_total
);
  import recip_pkg::*;

  logic                rst_n_i;
  logic                sig_rise;
  logic                periods_zero;
  logic                cnt_en;
  logic                dec_en;
  logic                wrap;
  meter_state_t        state_q, state_d;
  logic                ovf_q, ovf_d;
  logic [PRESET_W-1:0] preset_q, preset_d;

  recip_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk        (clk_ref),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  recip_edge_sync #(.STAGES(SYNC_W)) edge_i (
    .clk      (clk_ref),
    .rst_n    (rst_n_i),
    .async_in (sig_in),
    .rise     (sig_rise)
  );

  assign cnt_en = (state_q == ST_COUNT) && !periods_zero && !start;
  assign dec_en = cnt_en && sig_rise;

  recip_down_ctr #(.W(PRESET_W)) periods_i (
    .clk      (clk_ref),
    .rst_n    (rst_n_i),
    .load     (start),
    .load_val (preset_in),
    .dec      (dec_en),
    .zero     (periods_zero)
  );

  recip_ref_ctr #(.LO_W(LO_W), .HI_W(HI_W)) elapsed_i (
    .clk   (clk_ref),
    .rst_n (rst_n_i),
    .clr   (start),
    .en    (cnt_en),
    .total (ref_total),
    .wrap  (wrap)
  );

  always_comb begin
    state_d = state_q;
    if (start) begin
      state_d = ST_ARMED;
    end else begin
      unique case (state_q)
        ST_IDLE:  state_d = ST_IDLE;
        ST_ARMED: if (sig_rise)     state_d = ST_COUNT;
        ST_COUNT: if (periods_zero) state_d = ST_DONE;
        ST_DONE:  state_d = ST_DONE;
        default:  state_d = ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ovf_d = ovf_q;
    if (start)     ovf_d = 1'b0;
    else if (wrap) ovf_d = 1'b1;
  end

  always_comb begin
    preset_d = preset_q;
    if (start) preset_d = preset_in;
  end

  always_ff @(posedge clk_ref or negedge rst_n_i) begin
    if (!rst_n_i) begin
      state_q  <= ST_IDLE;
      ovf_q    <= 1'b0;
      preset_q <= '0;
    end else begin
      state_q  <= state_d;
      ovf_q    <= ovf_d;
      preset_q <= preset_d;
    end
  end

  assign done       = (state_q == ST_DONE);
  assign overflow   = ovf_q;
  assign preset_out = preset_q;
endmodule

// File: rtl/recip_freq_meter_chk.sv
module recip_freq_meter_chk #(
  parameter int PRESET_W = 24,
  parameter int TOT_W    = 40
) (
  input logic                clk_ref,
  input logic                rst_n,
  input logic                start,
  input logic [PRESET_W-1:0] preset_in,
  input logic                done,
  input logic                overflow,
  input logic [PRESET_W-1:0] preset_out,
  input logic [TOT_W-1:0]    ref_total
);
  AST_START_CLEARS: assert property (@(posedge clk_ref) disable iff (!rst_n)
    start |=> (!done && !overflow && ref_total == '0)); // R2

  AST_PRESET_LOAD: assert property (@(posedge clk_ref) disable iff (!rst_n)
    start |=> (preset_out == $past(preset_in))); // R2

  AST_TOTAL_STEP: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !start |=> (ref_total == $past(ref_total) || ref_total == $past(ref_total) + TOT_W'(1))); // R3

  AST_DONE_HOLD: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (done && !start) |=> done); // R4

  AST_TOTAL_FROZEN: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (done && !start) |=> $stable(ref_total)); // R5

  AST_OVF_STICKY: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (overflow && !start) |=> overflow); // R7

  AST_OVF_CAUSE: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (!start && $rose(overflow)) |-> (ref_total == '0)); // R7
endmodule

bind recip_freq_meter recip_freq_meter_chk #(
  .PRESET_W (PRESET_W),
  .TOT_W    (LO_W + HI_W)
) chk_i (
  .clk_ref    (clk_ref),
  .rst_n      (rst_n),
  .start      (start),
  .preset_in  (preset_in),
  .done       (done),
  .overflow   (overflow),
  .preset_out (preset_out),
  .ref_total  (ref_total)
);

// File: tb/recip_freq_meter_tb_top.sv
`timescale 1ns/1ps
module recip_freq_meter_tb_top;
  localparam int PW   = 8;
  localparam int LO   = 4;
  localparam int HI   = 4;
  localparam int TW   = LO + HI;
  localparam int LAT  = 4;

  typedef struct {
    int total;
    int preset;
    bit ovf;
  } exp_t;

  logic          clk_ref = 1'b0;
  logic          rst_n;
  logic          start;
  logic [PW-1:0] preset_in;
  logic          sig_in;
  logic          done;
  logic          overflow;
  logic [PW-1:0] preset_out;
  logic [TW-1:0] ref_total;

  int   checks   = 0;
  int   failures = 0;
  int   cyc      = 0;
  int   rise_cyc = 0;
  bit   done_seen = 1'b0;
  exp_t sb_q[$];

  always #2.5 clk_ref = ~clk_ref;
  always @(posedge clk_ref) cyc <= cyc + 1;

  recip_freq_meter #(.PRESET_W(PW), .LO_W(LO), .HI_W(HI)) dut_i (
    .clk_ref    (clk_ref),
    .rst_n      (rst_n),
    .start      (start),
    .preset_in  (preset_in),
    .sig_in     (sig_in),
    .done       (done),
    .overflow   (overflow),
    .preset_out (preset_out),
    .ref_total  (ref_total)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_start(input int n);
    @(negedge clk_ref);
    preset_in = PW'(n);
    start = 1'b1;
    @(negedge clk_ref);
    start = 1'b0;
    chk(preset_out == PW'(n), "R2 preset_out", int'(preset_out), n);
    chk(!done && !overflow && ref_total == '0, "R2 cleared", int'(ref_total), 0);
    repeat (3) @(negedge clk_ref);
  endtask

  task automatic drive_rises(input int count, input int p, input bit stamp_last);
    for (int k = 0; k < count; k++) begin
      sig_in = 1'b1;
      if (stamp_last && k == count - 1) rise_cyc = cyc;
      repeat (p / 2) @(negedge clk_ref);
      sig_in = 1'b0;
      repeat (p - p / 2) @(negedge clk_ref);
    end
  endtask

  task automatic measure(input int n, input int p, input bit exp_ovf, input string req);
    exp_t e;
    pulse_start(n);
    e.total  = (n * p) % (1 << TW);
    e.preset = n;
    e.ovf    = exp_ovf;
    sb_q.push_back(e);
    drive_rises(n + 1, p, 1'b1);
    for (int i = 0; i < 40 && !done; i++) @(negedge clk_ref);
    chk(done, {req, " done reached"}, int'(done), 1);
  endtask

  // Monitor: pops the expected item when done first appears.
  initial begin
    forever begin
      @(negedge clk_ref);
      if (done && !done_seen) begin
        if (sb_q.size() == 0) begin
          chk(1'b0, "R4 unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          chk(int'(ref_total) == e.total, "R3/R6 ref_total", int'(ref_total), e.total);
          chk(int'(preset_out) == e.preset, "R2 preset_out at done", int'(preset_out), e.preset);
          chk(overflow == e.ovf, "R7 overflow flag", int'(overflow), int'(e.ovf));
          chk(cyc - rise_cyc == LAT, "R4 done latency", cyc - rise_cyc, LAT);
        end
      end
      done_seen = done;
    end
  end

  initial begin
    repeat (150000) @(posedge clk_ref);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    preset_in = '0;
    sig_in = 1'b0;
    repeat (4) @(negedge clk_ref);
    chk(!done && !overflow, "R1 flags in reset", int'(done), 0);
    chk(ref_total == '0 && preset_out == '0, "R1 values in reset", int'(ref_total), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk_ref);
    chk(!done && !overflow && ref_total == '0, "R1 after release", int'(ref_total), 0);

    measure(5, 10, 1'b0, "R3");
    // R5: extra input rises after done must not move the result
    drive_rises(3, 10, 1'b0);
    repeat (6) @(negedge clk_ref);
    chk(int'(ref_total) == 50, "R5 total frozen", int'(ref_total), 50);
    chk(done, "R5 done held", int'(done), 1);

    measure(7, 33, 1'b0, "R6 carry");
    measure(2, 9, 1'b0, "R3 short");
    measure(1, 20, 1'b0, "R3 single");
    measure(0, 12, 1'b0, "R8");

    // R9: abandon a running measurement, then a clean one
    pulse_start(4);
    drive_rises(3, 10, 1'b0);
    chk(!done, "R9 not done before restart", int'(done), 0);
    measure(2, 12, 1'b0, "R9");

    // R7: slow stage wraps at 2^8 cycles in this build
    measure(3, 100, 1'b1, "R7");

    // R10: no input rises
    pulse_start(3);
    repeat (60) @(negedge clk_ref);
    chk(!done, "R10 done stays low", int'(done), 0);
    chk(ref_total == '0, "R10 total stays zero", int'(ref_total), 0);

    chk(sb_q.size() == 0, "R4 all results seen", sb_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule